// File: doc/BRIEF.md
# Crosspoint Configuration Register Bank

This block keeps the configuration state of a dual four-input, two-output analog crosspoint controller. A serial front end, which lies outside the block, decodes a transfer into a command byte and a data byte and presents both with a write strobe that lasts one clock. The command byte works as a select mask. Each of its six low bits picks one target register. The one data byte is then written into every picked register on the same clock edge, and every other register keeps its contents.

There are six targets. Four per-output switch registers each close any of four input switches and a shunt switch. One register drives four general-purpose logic outputs. One register holds a bias-network enable and a soft-switching (clickless) enable for each of the four outputs. The register contents are the outputs of the block and go straight to the switch drivers, the logic pins and the mode controls.

Top module: `xbar_cfg_bank`

## Requirements
- R1: While rst_n is low, and after it rises until the first write, all outputs are 0: every switch open, every logic output low, every bias and soft-switching enable off.
- R2: Command bit 0 selects output port 0, bit 1 port 1, bit 2 port 2 and bit 3 port 3. In the selected port's register, data bits 0..3 close input switches 0..3 (sw_close bit 4*port+input) and data bit 4 closes that port's shunt switch (sw_shunt bit port). 1 closes a switch and 0 opens it.
- R3: Data bits 5..7 have no effect on any switch register.
- R4: Command bit 4 selects the logic-output register. Data bits 0..3 drive aux_q[3:0] (1 = high) and data bits 4..7 are ignored.
- R5: Command bit 5 selects the mode register. Data bits 0..3 drive bias_en[3:0] and data bits 4..7 drive click_en[3:0]. 1 enables.
- R6: When several command bits are set, the same data byte loads into every selected register on the same edge.
- R7: A register whose command bit is 0 keeps its value, and no register changes while wr_stb is 0.
- R8: Command bits 6 and 7 select nothing.
- R9: A write presented with wr_stb at a rising clock edge shows on the outputs right after that edge, one register stage and no more.

Ports table:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| cmd | input | 8 | Command byte, a select mask |
| data | input | 8 | Data byte |
| sw_close | output | 16 | Input switch closures, 4 per port |
| sw_shunt | output | 4 | Shunt switch closure per port |
| aux_q | output | 4 | Logic outputs |
| bias_en | output | 4 | Bias network enable per port |
| click_en | output | 4 | Soft-switching enable per port |

## Verification
Each result is due exactly one rising edge after the strobe. The outputs come from a single register stage, and nothing is gated between those registers and the pins. The bench applies cmd, data and wr_stb at a falling edge and drops the strobe at the next falling edge. It compares all 32 output bits at that same falling edge, so the check falls after the loading edge and before any later one. An extra check samples just before the loading edge and confirms that the outputs still hold their old values.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_PORTS = 4;
  localparam int NUM_IN    = 4;
  localparam int SW_W      = NUM_IN + 1;        // inputs plus shunt
  localparam int SEL_W     = NUM_PORTS + 2;     // ports, aux, mode
  localparam int SEL_AUX   = NUM_PORTS;
  localparam int SEL_MODE  = NUM_PORTS + 1;
  localparam int AUX_W     = 4;
  localparam int MODE_W    = 2 * NUM_PORTS;

  // Bit index of a switch closure in the flat closure vector
  function automatic int sw_bit(input int port, input int inp);
    return port * NUM_IN + inp;
  endfunction
endpackage

// File: rtl/xbar_cmd_decode.sv
module xbar_cmd_decode
  import xbar_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] cmd,
  output logic [SEL_W-1:0]  wr_hit
);
  always_comb begin
    wr_hit = '0;
    if (wr_stb) wr_hit = cmd[SEL_W-1:0];
  end

  AST_NO_STROBE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> wr_hit == '0);  // R7
  AST_HIGH_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cmd[SEL_W-1:0] == '0 && cmd[BYTE_W-1:SEL_W] != '0) |-> wr_hit == '0);  // R8
endmodule

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(din));  // R9
  AST_UNSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));  // R7
endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
  import xbar_cfg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_stb,
  input  logic [BYTE_W-1:0]           cmd,
  input  logic [BYTE_W-1:0]           data,
  output logic [NUM_PORTS*NUM_IN-1:0] sw_close,
  output logic [NUM_PORTS-1:0]        sw_shunt,
  output logic [AUX_W-1:0]            aux_q,
  output logic [NUM_PORTS-1:0]        bias_en,
  output logic [NUM_PORTS-1:0]        click_en
);
  logic [SEL_W-1:0]  wr_hit;
  logic [AUX_W-1:0]  aux_r;
  logic [MODE_W-1:0] mode_r;

  xbar_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd(cmd), .wr_hit(wr_hit)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [SW_W-1:0] sw_r;
    xbar_cfg_reg #(.W(SW_W)) u_sw (
      .clk(clk), .rst_n(rst_n), .load(wr_hit[p]),
      .din(data[SW_W-1:0]), .q(sw_r)
    );
    assign sw_close[p*NUM_IN +: NUM_IN] = sw_r[NUM_IN-1:0];
    assign sw_shunt[p]                  = sw_r[NUM_IN];
  end

  xbar_cfg_reg #(.W(AUX_W)) u_aux (
    .clk(clk), .rst_n(rst_n), .load(wr_hit[SEL_AUX]),
    .din(data[AUX_W-1:0]), .q(aux_r)
  );
  xbar_cfg_reg #(.W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(wr_hit[SEL_MODE]),
    .din(data[MODE_W-1:0]), .q(mode_r)
  );

  assign aux_q    = aux_r;
  assign bias_en  = mode_r[NUM_PORTS-1:0];
  assign click_en = mode_r[MODE_W-1:NUM_PORTS];

  AST_SHARED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cmd[0] && cmd[2]) |=> (sw_close[NUM_IN-1:0] == sw_close[2*NUM_IN +: NUM_IN]
                                      && sw_shunt[0] == sw_shunt[2]));  // R6
  AST_SW_IGNORES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cmd[1]) |=> (sw_shunt[1] == $past(data[NUM_IN])
                            && sw_close[NUM_IN +: NUM_IN] == $past(data[NUM_IN-1:0])));  // R2
  AST_MODE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && cmd[SEL_MODE]) |=> {click_en, bias_en} == $past(data));  // R5
endmodule

// File: tb/xbar_cfg_bank_test.sv
module xbar_cfg_bank_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_stb = 0;
  logic [7:0] cmd = 0;
  logic [7:0] data = 0;
  logic [15:0] sw_close;
  logic [3:0]  sw_shunt, aux_q, bias_en, click_en;

  int checks = 0;
  int fails  = 0;

  // bench shadow state
  logic [4:0] m_sw [4];
  logic [3:0] m_aux, m_bias, m_click;

  always #10 clk = ~clk;  // 50 MHz

  xbar_cfg_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd(cmd), .data(data),
    .sw_close(sw_close), .sw_shunt(sw_shunt), .aux_q(aux_q),
    .bias_en(bias_en), .click_en(click_en)
  );

  typedef struct packed { logic [7:0] c; logic [7:0] d; } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 8'hFF},  // R2 R3 port0, top bits set
    '{8'h02, 8'h05},  // R2
    '{8'h04, 8'h1A},  // R2 shunt
    '{8'h08, 8'hE3},  // R3
    '{8'h10, 8'hF6},  // R4
    '{8'h20, 8'hA5},  // R5
    '{8'h0F, 8'h09},  // R6 all ports
    '{8'hC0, 8'hFF},  // R8
    '{8'h30, 8'h3C},  // R6 aux+mode
    '{8'h00, 8'hFF},  // R7
    '{8'hFF, 8'h00},  // R6 clear all
    '{8'h05, 8'h12}   // R6 R7
  };

  function automatic logic [31:0] expect_vec();
    logic [15:0] cl;
    logic [3:0]  sh;
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) cl[p*4+i] = m_sw[p][i];
      sh[p] = m_sw[p][4];
    end
    return {m_click, m_bias, m_aux, sh, cl};
  endfunction

  task automatic model_clear();
    for (int p = 0; p < 4; p++) m_sw[p] = '0;
    m_aux = 0; m_bias = 0; m_click = 0;
  endtask

  task automatic model_write(input logic [7:0] c, input logic [7:0] d);
    for (int p = 0; p < 4; p++) if (c[p]) m_sw[p] = {d[4], d[3], d[2], d[1], d[0]};
    if (c[4]) m_aux = d[3:0];
    if (c[5]) begin m_bias = d[3:0]; m_click = d[7:4]; end
  endtask

  task automatic check(input string req);
    logic [31:0] act, exp;
    act = {click_en, bias_en, aux_q, sw_shunt, sw_close};
    exp = expect_vec();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, strobe for one cycle, sample at next falling edge
  task automatic do_write(input logic [7:0] c, input logic [7:0] d, input logic stb);
    @(negedge clk);
    cmd = c; data = d; wr_stb = stb;
    @(negedge clk);
    wr_stb = 0;
    if (stb) model_write(c, d);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset");

    for (int k = 0; k < NV; k++) begin
      do_write(VECS[k].c, VECS[k].d, 1'b1);
      check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", k));
    end

    // R7: strobe low with full command, nothing changes
    do_write(8'h3F, 8'hFF, 1'b0);
    check("R7 no strobe");

    // R9: just before loading edge, old value; right after, new value
    @(negedge clk);
    cmd = 8'h10; data = 8'h0F; wr_stb = 1;
    #9;
    check("R9 before edge");
    @(negedge clk);
    wr_stb = 0;
    model_write(8'h10, 8'h0F);
    check("R9 after edge");

    // R4: high data bits ignored in aux register
    do_write(8'h10, 8'hF0, 1'b1);
    check("R4 high bits ignored");

    // R1: reset mid-run clears everything
    do_write(8'h3F, 8'hFF, 1'b1);
    check("R6 all set");
    @(negedge clk);
    rst_n = 0;
    model_clear();
    @(negedge clk);
    check("R1 mid-run reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 held after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule